// File: doc/BRIEF.md
# Banked Address Translator with Fault Classification

This block maps the 16-bit word addresses of a small processor onto a wider physical space made of devices and banks. The address space is cut into sixteen windows of 4K words each. A table of sixteen entries, one per window, names the device and bank that back the window and carries the protection flags for it. Every access request states its address, its kind (read, write or instruction fetch) and whether the processor runs in user or supervisor mode. The block replies with the physical device, bank and offset, a fault flag, a 3-bit fault type and a flag that says whether a write may really be carried out.

When translation is switched off, a fixed map applies. Window 0 selects either internal ROM bank 0 or internal RAM bank 0, chosen by a control input. Windows 1 to 15 select internal RAM banks 1 to 15. This fixed map never changes the table, so turning translation on again brings back the earlier mapping unchanged. The table is 32 words long and is written one word per strobe. Any word can be read back, so software can save and restore the whole table as a block.

The sequencing is a three-state machine. IDLE waits for a request and raises `req_ready`. The transition IDLE to EVAL is taken when a request is accepted, and the request fields are captured then. In EVAL the table entry is read, the access is classified, the results are registered and the accessed flag is updated. The transition EVAL to RESP is unconditional. RESP drives `rsp_valid` for one cycle. The transition RESP to IDLE is also unconditional.

Top module: `bank_mmu`

## Requirements
- R1: With translation on, `req_addr[15:12]` selects the entry and `rsp_off` equals `req_addr[11:0]`. `rsp_dev` is the high byte and `rsp_bank` is the low byte of the entry's mapping word. These outputs are reported even when the access faults.
- R2: Table word 2k is the mapping word of entry k and word 2k+1 is its flag word. Flag bits are: bit 0 not present, bit 1 accessed, bit 2 write protect, bit 3 execute protect, bit 4 supervisor only, bit 5 ROM device. A word is written on a clock edge where `tbl_we` is high. `tbl_rdata` shows the word at `tbl_idx` without delay.
- R3: An access through an entry marked not present faults with type 000, whatever the other flags say.
- R4: A user-mode access to a supervisor-only entry faults. A write gives type 110; a read or a fetch gives type 100.
- R5: If R3 and R4 do not apply, a fetch from an execute-protected entry faults with type 001.
- R6: If R3, R4 and R5 do not apply, a write to a write-protected entry faults with type 010. This also holds for ROM entries.
- R7: A write to a ROM entry without write protect gives no fault and `rsp_wr_en` low. A faulting access always has `rsp_wr_en` low. A response without a fault has type 000.
- R8: The accessed bit of an entry is set only by a translated write that is performed, meaning no fault and no ROM. Reads, fetches, faulting writes and dropped ROM writes leave it unchanged.
- R9: With translation off, window n maps to device 0x00 bank n, except window 0 when `ram0_sel` is 0: it maps to device 0x01 (internal ROM) bank 0. A write there gives `rsp_wr_en` low. The fixed map never faults.
- R10: Switching translation off and on leaves the table unchanged and restores the earlier mapping.
- R11: `req_kind` is coded 00 read, 01 write, 10 fetch, 11 read. A request is accepted when `req_valid` and `req_ready` are both high. `rsp_valid` is high exactly two cycles later, for one cycle only, and `req_ready` stays low until then.
- R12: After reset the table is all zero, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_en | input | 1 | Translation enable, sampled when a request is accepted |
| ram0_sel | input | 1 | Selects RAM (1) or ROM (0) for window 0 when translation is off |
| user_mode | input | 1 | Mode of the request: 1 for user, 0 for supervisor |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block is idle and can accept a request |
| req_addr | input | 16 | Word address to translate |
| req_kind | input | 2 | Access kind |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | The access raised a bank fault |
| rsp_code | output | 3 | Fault type |
| rsp_dev | output | 8 | Physical device |
| rsp_bank | output | 8 | Physical bank |
| rsp_off | output | 12 | Offset within the bank |
| rsp_wr_en | output | 1 | The write may be carried out |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 5 | Table word index |
| tbl_wdata | input | 16 | Table write data |
| tbl_rdata | output | 16 | Table word at `tbl_idx` |

## Verification
A request accepted at a clock edge has its response two edges later: one edge to move into EVAL and one to register the result. The bench drives each request half a cycle before its edge, and its monitor compares the response at the falling edge that follows the second edge. The driver also checks at the first falling edge after acceptance that `req_ready` and `rsp_valid` are both low. Table write and readback go through the combinational read port, which is sampled one time unit after the index changes. The accessed bit is read back after the response, by which time it has been updated in the EVAL cycle.

// File: rtl/bmmu_pkg.sv
package bmmu_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_FETCH = 2'b10,
        KIND_ALT   = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_EVAL = 2'b01,
        ST_RESP = 2'b10
    } state_e;

    // flag word bit positions
    localparam int FLG_ABSENT = 0;
    localparam int FLG_ACC    = 1;
    localparam int FLG_WPROT  = 2;
    localparam int FLG_XPROT  = 3;
    localparam int FLG_SUPER  = 4;
    localparam int FLG_ROM    = 5;
    localparam int FLAG_W     = 6;

    // fault type codes, bit order U W E
    localparam logic [2:0] FT_ABSENT   = 3'b000;
    localparam logic [2:0] FT_XPROT    = 3'b001;
    localparam logic [2:0] FT_WPROT    = 3'b010;
    localparam logic [2:0] FT_USER_RD  = 3'b100;
    localparam logic [2:0] FT_USER_WR  = 3'b110;

    // fixed-map device codes
    localparam logic [7:0] DEV_INT_RAM = 8'h00;
    localparam logic [7:0] DEV_INT_ROM = 8'h01;

endpackage

// File: rtl/bmmu_table.sv
module bmmu_table
    import bmmu_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int WORD_W  = 16,
    localparam int WORDS  = 2 * ENTRIES,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int SEL_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic [SEL_W-1:0]  xl_sel,
    output logic [WORD_W-1:0] xl_map,
    output logic [FLAG_W-1:0] xl_flags,
    input  logic              acc_set,
    input  logic [SEL_W-1:0]  acc_sel
);

    logic [WORD_W-1:0] mem [WORDS];
    logic [WORD_W-1:0] flag_word;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (acc_set) begin
                mem[{acc_sel, 1'b1}][FLG_ACC] <= 1'b1;
            end
            // a host write to the same word takes precedence
            if (host_we) begin
                mem[host_idx] <= host_wdata;
            end
        end
    end

    always_comb begin
        host_rdata = mem[host_idx];
        xl_map     = mem[{xl_sel, 1'b0}];
        flag_word  = mem[{xl_sel, 1'b1}];
        xl_flags   = flag_word[FLAG_W-1:0];
    end

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_acc_chk
            // R8
            acc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(mem[2*e+1][FLG_ACC]) |-> $past(host_we));
            // R8
            acc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(mem[2*e+1][FLG_ACC]) |-> $past(host_we || (acc_set && acc_sel == SEL_W'(e))));
        end
    endgenerate

endmodule

// File: rtl/bmmu_classify.sv
module bmmu_classify
    import bmmu_pkg::*;
#(
    parameter int SEL_W  = 4,
    parameter int DEV_W  = 8,
    parameter int BANK_W = 8,
    localparam int MAP_W = DEV_W + BANK_W
) (
    input  logic              map_on,
    input  logic              ram0,
    input  logic              user,
    input  kind_e             kind,
    input  logic [SEL_W-1:0]  sel,
    input  logic [MAP_W-1:0]  map_word,
    input  logic [FLAG_W-1:0] flags,
    output logic              fault,
    output logic [2:0]        code,
    output logic [DEV_W-1:0]  dev,
    output logic [BANK_W-1:0] bank,
    output logic              wr_ok,
    output logic              mark_acc
);

    logic is_wr;
    logic is_fx;
    logic rom_win0;

    always_comb begin
        is_wr    = (kind == KIND_WRITE);
        is_fx    = (kind == KIND_FETCH);
        rom_win0 = (sel == '0) && !ram0;
        fault    = 1'b0;
        code     = 3'b000;
        mark_acc = 1'b0;
        if (!map_on) begin
            dev   = rom_win0 ? DEV_W'(DEV_INT_ROM) : DEV_W'(DEV_INT_RAM);
            bank  = BANK_W'(sel);
            wr_ok = is_wr && !rom_win0;
        end else begin
            dev  = map_word[MAP_W-1:BANK_W];
            bank = map_word[BANK_W-1:0];
            if (flags[FLG_ABSENT]) begin
                fault = 1'b1;
                code  = FT_ABSENT;
            end else if (user && flags[FLG_SUPER]) begin
                fault = 1'b1;
                code  = is_wr ? FT_USER_WR : FT_USER_RD;
            end else if (is_fx && flags[FLG_XPROT]) begin
                fault = 1'b1;
                code  = FT_XPROT;
            end else if (is_wr && flags[FLG_WPROT]) begin
                fault = 1'b1;
                code  = FT_WPROT;
            end
            wr_ok    = is_wr && !fault && !flags[FLG_ROM];
            mark_acc = wr_ok;
        end
    end

endmodule

// File: rtl/bank_mmu.sv
module bank_mmu
    import bmmu_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int SEL_W   = 4,
    parameter int DEV_W   = 8,
    parameter int BANK_W  = 8,
    localparam int OFF_W   = ADDR_W - SEL_W,
    localparam int ENTRIES = 2 ** SEL_W,
    localparam int WORD_W  = DEV_W + BANK_W,
    localparam int IDX_W   = SEL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_en,
    input  logic              ram0_sel,
    input  logic              user_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [2:0]        rsp_code,
    output logic [DEV_W-1:0]  rsp_dev,
    output logic [BANK_W-1:0] rsp_bank,
    output logic [OFF_W-1:0]  rsp_off,
    output logic              rsp_wr_en,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic [WORD_W-1:0] tbl_wdata,
    output logic [WORD_W-1:0] tbl_rdata
);

    state_e state_q, state_d;
    logic   accept;

    logic [ADDR_W-1:0] addr_q;
    kind_e             kind_q;
    logic              user_q, map_q, ram0_q;

    logic [WORD_W-1:0] xl_map;
    logic [FLAG_W-1:0] xl_flags;
    logic              c_fault, c_wr_ok, c_mark;
    logic [2:0]        c_code;
    logic [DEV_W-1:0]  c_dev;
    logic [BANK_W-1:0] c_bank;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state decoded outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_EVAL: ;
            ST_RESP: rsp_valid = 1'b1;
            default: ;
        endcase
    end

    assign accept = req_valid && req_ready;

    // request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            kind_q <= KIND_READ;
            user_q <= 1'b0;
            map_q  <= 1'b0;
            ram0_q <= 1'b0;
        end else if (accept) begin
            addr_q <= req_addr;
            kind_q <= kind_e'(req_kind);
            user_q <= user_mode;
            map_q  <= map_en;
            ram0_q <= ram0_sel;
        end
    end

    bmmu_table #(
        .ENTRIES (ENTRIES),
        .WORD_W  (WORD_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (tbl_we),
        .host_idx   (tbl_idx),
        .host_wdata (tbl_wdata),
        .host_rdata (tbl_rdata),
        .xl_sel     (addr_q[ADDR_W-1:OFF_W]),
        .xl_map     (xl_map),
        .xl_flags   (xl_flags),
        .acc_set    ((state_q == ST_EVAL) && c_mark),
        .acc_sel    (addr_q[ADDR_W-1:OFF_W])
    );

    bmmu_classify #(
        .SEL_W  (SEL_W),
        .DEV_W  (DEV_W),
        .BANK_W (BANK_W)
    ) u_classify (
        .map_on   (map_q),
        .ram0     (ram0_q),
        .user     (user_q),
        .kind     (kind_q),
        .sel      (addr_q[ADDR_W-1:OFF_W]),
        .map_word (xl_map),
        .flags    (xl_flags),
        .fault    (c_fault),
        .code     (c_code),
        .dev      (c_dev),
        .bank     (c_bank),
        .wr_ok    (c_wr_ok),
        .mark_acc (c_mark)
    );

    // result register, loaded in EVAL
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_fault <= 1'b0;
            rsp_code  <= 3'b000;
            rsp_dev   <= '0;
            rsp_bank  <= '0;
            rsp_off   <= '0;
            rsp_wr_en <= 1'b0;
        end else if (state_q == ST_EVAL) begin
            rsp_fault <= c_fault;
            rsp_code  <= c_code;
            rsp_dev   <= c_dev;
            rsp_bank  <= c_bank;
            rsp_off   <= addr_q[OFF_W-1:0];
            rsp_wr_en <= c_wr_ok;
        end
    end

    // R11
    resp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ##2 rsp_valid);
    // R11
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R11
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R7
    fault_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> !rsp_wr_en);
    // R9
    fixed_map_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !map_q) |-> !rsp_fault);
    // R7
    clean_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_code == 3'b000));

endmodule

// File: tb/bank_mmu_tb_top.sv
module bank_mmu_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_en = 1'b0, ram0_sel = 1'b0, user_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        rsp_valid, rsp_fault, rsp_wr_en;
    logic [2:0]  rsp_code;
    logic [7:0]  rsp_dev, rsp_bank;
    logic [11:0] rsp_off;
    logic        tbl_we = 1'b0;
    logic [4:0]  tbl_idx = '0;
    logic [15:0] tbl_wdata = '0;
    logic [15:0] tbl_rdata;

    int checks = 0;
    int errors = 0;
    logic [15:0] sh [32];
    logic [32:0] exp_q [$];
    string       tag_q [$];
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_mmu dut_i (
        .clk(clk), .rst_n(rst_n), .map_en(map_en), .ram0_sel(ram0_sel),
        .user_mode(user_mode), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_kind(req_kind), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_code(rsp_code), .rsp_dev(rsp_dev),
        .rsp_bank(rsp_bank), .rsp_off(rsp_off), .rsp_wr_en(rsp_wr_en),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata),
        .tbl_rdata(tbl_rdata)
    );

    task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bench model of the requirements; result {fault,code,dev,bank,off,wr}
    function automatic logic [32:0] model(input logic [15:0] a, input logic [1:0] k, input logic u);
        logic [3:0]  n = a[15:12];
        logic [15:0] mw = sh[{n, 1'b0}];
        logic [15:0] fw = sh[{n, 1'b1}];
        logic        wr = (k == 2'b01);
        logic        fx = (k == 2'b10);
        logic        f = 0;
        logic [2:0]  c = 3'b000;
        logic [7:0]  d, b;
        logic        we;
        if (!map_en) begin
            d  = (n == 0 && !ram0_sel) ? 8'h01 : 8'h00;
            b  = {4'h0, n};
            we = wr && !(n == 0 && !ram0_sel);
        end else begin
            d = mw[15:8];
            b = mw[7:0];
            if (fw[0]) begin f = 1; c = 3'b000; end
            else if (u && fw[4]) begin f = 1; c = wr ? 3'b110 : 3'b100; end
            else if (fx && fw[3]) begin f = 1; c = 3'b001; end
            else if (wr && fw[2]) begin f = 1; c = 3'b010; end
            we = wr && !f && !fw[5];
        end
        return {f, c, d, b, a[11:0], we};
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11 unexpected response actual=1 expected=0");
            end else begin
                check(tag_q.pop_front(),
                      {rsp_fault, rsp_code, rsp_dev, rsp_bank, rsp_off, rsp_wr_en},
                      exp_q.pop_front());
            end
        end
    end

    task automatic access(input logic [15:0] a, input logic [1:0] k, input logic u, input string tag);
        logic [32:0] e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e = model(a, k, u);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (map_en && e[0]) sh[{a[15:12], 1'b1}][1] = 1'b1;
        req_addr = a; req_kind = k; user_mode = u; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        // R11: busy and no response one cycle after acceptance
        check("R11 busy", {31'b0, req_ready, rsp_valid}, 33'b0);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic twrite(input logic [4:0] i, input logic [15:0] d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = i; tbl_wdata = d;
        @(negedge clk);
        tbl_we = 1'b0;
        sh[i] = d;
    endtask

    task automatic tread(input logic [4:0] i, input string tag);
        @(negedge clk);
        tbl_idx = i;
        #1;
        check(tag, {17'b0, tbl_rdata}, {17'b0, sh[i]});
    endtask

    initial begin
        for (int i = 0; i < 32; i++) sh[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12
        check("R12 idle", {31'b0, req_ready, rsp_valid}, {31'b0, 1'b1, 1'b0});
        tread(5'd3, "R12 table zero");

        // fixed map, R9
        map_en = 0; ram0_sel = 0;
        access(16'h0123, 2'b00, 0, "R9 rom read");
        access(16'h0456, 2'b01, 0, "R9 rom write dropped");
        ram0_sel = 1;
        access(16'h0456, 2'b01, 0, "R9 ram0 write");
        access(16'hA7FF, 2'b11, 1, "R9 window A");

        // load table, R2
        twrite(5'd0,  16'h0205); twrite(5'd1,  16'h0000);
        twrite(5'd2,  16'h0310); twrite(5'd3,  16'h001D);
        twrite(5'd4,  16'h0420); twrite(5'd5,  16'h0010);
        twrite(5'd6,  16'h0430); twrite(5'd7,  16'h0008);
        twrite(5'd8,  16'h0440); twrite(5'd9,  16'h0004);
        twrite(5'd10, 16'h0950); twrite(5'd11, 16'h0020);
        twrite(5'd12, 16'h0960); twrite(5'd13, 16'h0024);
        twrite(5'd30, 16'h7FEE); twrite(5'd31, 16'h0000);
        tread(5'd2, "R2 map word");
        tread(5'd3, "R2 flag word");

        map_en = 1;
        access(16'h0ABC, 2'b00, 0, "R1 translate");
        access(16'h1000, 2'b10, 1, "R3 absent priority");
        access(16'h2000, 2'b01, 1, "R4 user write");
        access(16'h2001, 2'b00, 1, "R4 user read");
        access(16'h2002, 2'b10, 1, "R4 user fetch");
        access(16'h2003, 2'b01, 0, "R4 super write ok");
        access(16'h3000, 2'b10, 0, "R5 fetch xprot");
        access(16'h3004, 2'b00, 0, "R5 read xprot ok");
        access(16'h4000, 2'b01, 0, "R6 write wprot");
        access(16'h5000, 2'b01, 0, "R7 rom write silent");
        access(16'h6000, 2'b01, 0, "R6 rom wprot");
        access(16'hF123, 2'b01, 0, "R1 write window F");
        tread(5'd31, "R8 acc set");
        tread(5'd5,  "R8 acc super write");
        tread(5'd9,  "R8 acc faulted");
        tread(5'd11, "R8 acc rom");
        tread(5'd1,  "R8 acc read");

        // R10
        map_en = 0;
        access(16'hF000, 2'b00, 0, "R10 fixed F");
        tread(5'd30, "R10 table kept");
        map_en = 1;
        access(16'hF000, 2'b00, 0, "R10 restored");

        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R11 missing responses actual=%0d expected=0", exp_q.size());
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule